// File: doc/BRIEF.md
# Overlay Segment Slot Allocator

A memory controller keeps each page overlay in a compact segment. The segment comes in one of four small size classes, or in a full-page class. This block holds the per-segment bookkeeping for one such segment. For each of the 64 lines of a page it keeps a 5-bit pointer to the slot that stores that line. It also keeps a vector that marks which slots are still unused. Slot 0 is the segment's header line, so a pointer of 0 means the line is not in the overlay.

Two kinds of request reach the block. A dirty-line writeback names a line index. The block answers with the byte offset of that line's slot, taking the lowest free slot if the line has none yet. When a new slot is needed and none is free, the block raises a grow request so that the segment can be moved to a larger class, and it leaves its bookkeeping as it was. A read names a line index and gets back either the byte offset of the line in the segment or an indication that the line is absent. In the full-page class no pointers are used and every line sits at its natural page offset. A segment-load pulse sets the class and clears all bookkeeping.

Top module: `ovl_slot_alloc`

## Requirements
- R1: After reset no response is pending (wb_ack, rd_ack and grow_req low). The segment is the 256 B class with no line present.
- R2: A pulse on seg_init loads seg_class and marks every line absent. Class codes are 0=256 B, 1=512 B, 2=1 KB and 3=2 KB, and any code from 4 to 7 is the 4 KB full-page class. For a small class the free slots become 1 to (4<<class)-1.
- R3: A writeback to an absent line in a small class with a free slot is answered one cycle later with wb_ack=1, wb_alloc=1 and wb_offset = 64 × (lowest free slot number). That slot is then no longer free.
- R4: A writeback to a line that already has a slot is answered with wb_alloc=0 and wb_offset = 64 × its slot, and it changes nothing.
- R5: A writeback to an absent line when no slot is free is answered with wb_ack=1, grow_req=1, wb_alloc=0 and wb_offset=0. The line stays absent and the free slots are left unchanged.
- R6: A read is answered one cycle later with rd_ack=1. For a present line in a small class it gives rd_present=1 and rd_offset = 64 × slot. For an absent line it gives rd_present=0 and rd_offset=0.
- R7: In the full-page class every read gives rd_present=1 and rd_offset = 64 × line. Every writeback gives wb_offset = 64 × line, wb_alloc=0 and grow_req=0.
- R8: The number of lines that can be placed before a grow request is 3, 7, 15 and 31 for class codes 0, 1, 2 and 3.
- R9: A writeback or read presented in the same cycle as seg_init gets no response and has no effect on the state.
- R10: A read and a writeback presented in the same cycle are both answered. The read reflects the state before that writeback.
- R11: Placing further lines never changes the slot of a line already placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_init | input | 1 | Load a new segment class and clear bookkeeping |
| seg_class | input | 3 | Size class code for seg_init |
| wb_valid | input | 1 | Dirty-line writeback request |
| wb_line | input | 6 | Line index of the writeback |
| rd_valid | input | 1 | Read translation request |
| rd_line | input | 6 | Line index of the read |
| wb_ack | output | 1 | Writeback answered this cycle |
| wb_alloc | output | 1 | A new slot was taken for the writeback |
| grow_req | output | 1 | Segment full, must move to a larger class |
| wb_offset | output | 12 | Byte offset of the written line in the segment |
| rd_ack | output | 1 | Read answered this cycle |
| rd_present | output | 1 | The read line is in the overlay |
| rd_offset | output | 12 | Byte offset of the read line in the segment |

## Verification
The assertions assume that each request is a single-cycle pulse with a stable line index in that cycle. They also assume that seg_init is the only way the class changes, so that a response always belongs to the class in force when it was sampled. The stimulus raises each request for exactly one cycle. It changes inputs only between clock edges and issues seg_init at the points where a new segment would be handed over. In one step it deliberately combines seg_init with both requests to check that they are dropped.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
    localparam int LINES      = 64;
    localparam int LINE_W     = $clog2(LINES);
    localparam int BYTE_W     = 6;
    localparam int OFF_W      = LINE_W + BYTE_W;
    localparam int SLOT_W     = 5;
    localparam int SLOTS      = 1 << SLOT_W;
    localparam int CLASS_W    = 3;
    localparam int CLASS_FULL = 4;

    typedef struct packed {
        logic [CLASS_W-1:0]            cls;
        logic [LINES-1:0][SLOT_W-1:0]  ptr;
        logic [SLOTS-1:0]              free;
        logic                          wb_ack;
        logic                          wb_alloc;
        logic                          grow;
        logic [OFF_W-1:0]              wb_off;
        logic                          rd_ack;
        logic                          rd_pres;
        logic [OFF_W-1:0]              rd_off;
    } seg_state_t;

    function automatic logic [SLOTS-1:0] free_mask(input logic [CLASS_W-1:0] cls);
        logic [SLOTS-1:0] m;
        int               cnt;
        m = '0;
        if (int'(cls) < CLASS_FULL) begin
            cnt = (4 << int'(cls)) - 1;
            for (int i = 1; i < SLOTS; i++) begin
                m[i] = (i <= cnt);
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/ovl_free_pick.sv
`timescale 1ns/1ps
module ovl_free_pick
    import ovl_pkg::*;
(
    input  logic [SLOTS-1:0]  free_vec,
    output logic              pick_valid,
    output logic [SLOT_W-1:0] pick_slot
);
    always_comb begin
        pick_valid = 1'b0;
        pick_slot  = '0;
        for (int i = SLOTS - 1; i >= 1; i--) begin
            if (free_vec[i]) begin
                pick_valid = 1'b1;
                pick_slot  = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ovl_offset_calc.sv
`timescale 1ns/1ps
module ovl_offset_calc
    import ovl_pkg::*;
(
    input  logic              full_page,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic [OFF_W-1:0]  byte_off
);
    always_comb begin
        if (full_page) begin
            byte_off = OFF_W'(line_idx) << BYTE_W;
        end else begin
            byte_off = OFF_W'(slot_idx) << BYTE_W;
        end
    end
endmodule

// File: rtl/ovl_slot_alloc.sv
`timescale 1ns/1ps
module ovl_slot_alloc
    import ovl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seg_init,
    input  logic [CLASS_W-1:0] seg_class,
    input  logic               wb_valid,
    input  logic [LINE_W-1:0]  wb_line,
    input  logic               rd_valid,
    input  logic [LINE_W-1:0]  rd_line,
    output logic               wb_ack,
    output logic               wb_alloc,
    output logic               grow_req,
    output logic [OFF_W-1:0]   wb_offset,
    output logic               rd_ack,
    output logic               rd_present,
    output logic [OFF_W-1:0]   rd_offset
);
    seg_state_t st_d, st_q;

    logic              full_q;
    logic [SLOT_W-1:0] rd_slot;
    logic [SLOT_W-1:0] wb_cur_slot;
    logic [SLOT_W-1:0] wb_sel_slot;
    logic              pick_valid;
    logic [SLOT_W-1:0] pick_slot;
    logic [OFF_W-1:0]  rd_off_calc;
    logic [OFF_W-1:0]  wb_off_calc;
    logic [SLOTS-1:0]  free_q;
    logic [CLASS_W-1:0] cls_q;

    assign full_q      = int'(st_q.cls) >= CLASS_FULL;
    assign rd_slot     = st_q.ptr[rd_line];
    assign wb_cur_slot = st_q.ptr[wb_line];
    assign wb_sel_slot = (wb_cur_slot != '0) ? wb_cur_slot : pick_slot;
    assign free_q      = st_q.free;
    assign cls_q       = st_q.cls;

    ovl_free_pick u_pick (
        .free_vec   (st_q.free),
        .pick_valid (pick_valid),
        .pick_slot  (pick_slot)
    );

    ovl_offset_calc u_rd_off (
        .full_page (full_q),
        .line_idx  (rd_line),
        .slot_idx  (rd_slot),
        .byte_off  (rd_off_calc)
    );

    ovl_offset_calc u_wb_off (
        .full_page (full_q),
        .line_idx  (wb_line),
        .slot_idx  (wb_sel_slot),
        .byte_off  (wb_off_calc)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wb_ack   = 1'b0;
        st_d.wb_alloc = 1'b0;
        st_d.grow     = 1'b0;
        st_d.wb_off   = '0;
        st_d.rd_ack   = 1'b0;
        st_d.rd_pres  = 1'b0;
        st_d.rd_off   = '0;

        if (seg_init) begin
            st_d.cls  = seg_class;
            st_d.ptr  = '0;
            st_d.free = free_mask(seg_class);
        end else begin
            if (rd_valid) begin
                st_d.rd_ack = 1'b1;
                if (full_q || rd_slot != '0) begin
                    st_d.rd_pres = 1'b1;
                    st_d.rd_off  = rd_off_calc;
                end
            end
            if (wb_valid) begin
                st_d.wb_ack = 1'b1;
                if (full_q || wb_cur_slot != '0) begin
                    st_d.wb_off = wb_off_calc;
                end else if (pick_valid) begin
                    st_d.ptr[wb_line]    = pick_slot;
                    st_d.free[pick_slot] = 1'b0;
                    st_d.wb_alloc        = 1'b1;
                    st_d.wb_off          = wb_off_calc;
                end else begin
                    st_d.grow = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.free     <= free_mask('0);
        end else begin
            st_q <= st_d;
        end
    end

    assign wb_ack     = st_q.wb_ack;
    assign wb_alloc   = st_q.wb_alloc;
    assign grow_req   = st_q.grow;
    assign wb_offset  = st_q.wb_off;
    assign rd_ack     = st_q.rd_ack;
    assign rd_present = st_q.rd_pres;
    assign rd_offset  = st_q.rd_off;
endmodule

// File: rtl/ovl_slot_alloc_chk.sv
`timescale 1ns/1ps
module ovl_slot_alloc_chk
    import ovl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               seg_init,
    input logic               wb_valid,
    input logic               rd_valid,
    input logic               wb_ack,
    input logic               wb_alloc,
    input logic               grow_req,
    input logic               rd_ack,
    input logic               rd_present,
    input logic [OFF_W-1:0]   rd_offset,
    input logic [SLOTS-1:0]   free_q,
    input logic [CLASS_W-1:0] cls_q
);
    p_wb_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !seg_init) |=> wb_ack);

    p_rd_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !seg_init) |=> rd_ack);

    p_init_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_init |=> (!wb_ack && !rd_ack));

    p_grow_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grow_req |-> (free_q == '0 && $stable(free_q)));

    p_alloc_takes_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_alloc |-> ($countones(free_q) + 1 == $past($countones(free_q))));

    p_alloc_or_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_alloc && grow_req));

    p_full_always_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && int'(cls_q) >= CLASS_FULL) |-> rd_present);

    p_line_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_present |-> (rd_offset[BYTE_W-1:0] == '0));
endmodule

bind ovl_slot_alloc ovl_slot_alloc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_init   (seg_init),
    .wb_valid   (wb_valid),
    .rd_valid   (rd_valid),
    .wb_ack     (wb_ack),
    .wb_alloc   (wb_alloc),
    .grow_req   (grow_req),
    .rd_ack     (rd_ack),
    .rd_present (rd_present),
    .rd_offset  (rd_offset),
    .free_q     (free_q),
    .cls_q      (cls_q)
);

// File: tb/ovl_slot_alloc_bench.sv
`timescale 1ns/1ps
module ovl_slot_alloc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_init = 1'b0;
    logic [2:0]  seg_class = '0;
    logic        wb_valid = 1'b0;
    logic [5:0]  wb_line = '0;
    logic        rd_valid = 1'b0;
    logic [5:0]  rd_line = '0;
    logic        wb_ack, wb_alloc, grow_req, rd_ack, rd_present;
    logic [11:0] wb_offset, rd_offset;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ovl_slot_alloc u_ovl_slot_alloc (
        .clk(clk), .rst_n(rst_n), .seg_init(seg_init), .seg_class(seg_class),
        .wb_valid(wb_valid), .wb_line(wb_line), .rd_valid(rd_valid), .rd_line(rd_line),
        .wb_ack(wb_ack), .wb_alloc(wb_alloc), .grow_req(grow_req), .wb_offset(wb_offset),
        .rd_ack(rd_ack), .rd_present(rd_present), .rd_offset(rd_offset)
    );

    // reference model
    bit m_full;
    int m_ptr [64];
    bit m_free [32];

    // scoreboard queues: wb {grow, alloc, offset}, rd {present, offset}
    logic [13:0] wb_q [$];
    string       wb_tag_q [$];
    logic [12:0] rd_q [$];
    string       rd_tag_q [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_init(input int cls);
        m_full = (cls >= 4);
        for (int i = 0; i < 64; i++) m_ptr[i] = 0;
        for (int i = 0; i < 32; i++) m_free[i] = !m_full && i >= 1 && i <= (4 << cls) - 1;
    endtask

    task automatic push_wb(input int line, input string tag);
        int pick;
        pick = 0;
        if (m_full) begin
            wb_q.push_back({1'b0, 1'b0, 12'(line * 64)});
        end else if (m_ptr[line] != 0) begin
            wb_q.push_back({1'b0, 1'b0, 12'(m_ptr[line] * 64)});
        end else begin
            for (int i = 31; i >= 1; i--) if (m_free[i]) pick = i;
            if (pick != 0) begin
                m_ptr[line] = pick;
                m_free[pick] = 0;
                wb_q.push_back({1'b0, 1'b1, 12'(pick * 64)});
            end else begin
                wb_q.push_back({1'b1, 1'b0, 12'd0});
            end
        end
        wb_tag_q.push_back(tag);
    endtask

    task automatic push_rd(input int line, input string tag);
        if (m_full) rd_q.push_back({1'b1, 12'(line * 64)});
        else if (m_ptr[line] != 0) rd_q.push_back({1'b1, 12'(m_ptr[line] * 64)});
        else rd_q.push_back({1'b0, 12'd0});
        rd_tag_q.push_back(tag);
    endtask

    task automatic drive(input bit ini, input int cls, input bit wv, input int wl, input bit rv, input int rl);
        @(negedge clk);
        seg_init  = ini;
        seg_class = 3'(cls);
        wb_valid  = wv;
        wb_line   = 6'(wl);
        rd_valid  = rv;
        rd_line   = 6'(rl);
    endtask

    task automatic op_wb(input int line, input string tag);
        drive(0, 0, 1, line, 0, 0);
        push_wb(line, tag);
    endtask

    task automatic op_rd(input int line, input string tag);
        drive(0, 0, 0, 0, 1, line);
        push_rd(line, tag);
    endtask

    task automatic op_both(input int rl, input int wl, input string tag);
        drive(0, 0, 1, wl, 1, rl);
        push_rd(rl, tag);
        push_wb(wl, tag);
    endtask

    task automatic op_init(input int cls, input bit wv, input int wl, input bit rv, input int rl);
        drive(1, cls, wv, wl, rv, rl);
        m_init(cls);
    endtask

    task automatic idle(input int n);
        drive(0, 0, 0, 0, 0, 0);
        repeat (n) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wb_ack) begin
                if (wb_q.size() == 0) begin
                    check(0, "R9 unexpected wb answer", 32'(wb_offset), 32'hFFFF_FFFF);
                end else begin
                    logic [13:0] e;
                    string t;
                    e = wb_q.pop_front();
                    t = wb_tag_q.pop_front();
                    check({grow_req, wb_alloc, wb_offset} == e, {t, " wb"},
                          32'({grow_req, wb_alloc, wb_offset}), 32'(e));
                end
            end
            if (rd_ack) begin
                if (rd_q.size() == 0) begin
                    check(0, "R9 unexpected rd answer", 32'(rd_offset), 32'hFFFF_FFFF);
                end else begin
                    logic [12:0] e;
                    string t;
                    e = rd_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check({rd_present, rd_offset} == e, {t, " rd"},
                          32'({rd_present, rd_offset}), 32'(e));
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            check(0, "watchdog", 32'(total), 32'(0));
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_init(0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(!wb_ack && !rd_ack && !grow_req, "R1 reset outputs",
              32'({wb_ack, rd_ack, grow_req}), 32'd0);
        op_rd(5, "R1 empty after reset");

        // R2/R3/R4/R5/R8/R11: 256 B class
        op_init(0, 0, 0, 0, 0);
        op_wb(10, "R3 first alloc");
        op_wb(3, "R3 next lowest");
        op_wb(10, "R4 existing slot");
        op_wb(60, "R8 third line");
        op_wb(7, "R5 grow when full");
        op_rd(7, "R5 line stays absent");
        op_rd(10, "R11 slot kept");
        op_rd(3, "R11 slot kept");
        op_rd(60, "R6 present");
        op_rd(0, "R6 absent");

        // R8: 2 KB class holds 31
        op_init(3, 0, 0, 0, 0);
        for (int l = 0; l < 32; l++) op_wb(l, "R8 2KB fill");
        op_rd(30, "R8 last slot");
        op_rd(31, "R8 overflow absent");
        op_rd(0, "R11 first line kept");

        // R10: same-cycle read and writeback on 512 B class
        op_init(1, 0, 0, 0, 0);
        op_both(5, 5, "R10 read before write");
        op_rd(5, "R10 after write");

        // R9: requests during seg_init are dropped
        op_init(2, 1, 9, 1, 5);
        op_rd(5, "R9 cleared by init");
        op_rd(9, "R9 no alloc during init");
        op_wb(9, "R2 1KB starts at slot1");

        // R7: full-page classes
        op_init(4, 0, 0, 0, 0);
        op_rd(17, "R7 natural offset");
        op_wb(63, "R7 wb no alloc");
        op_rd(0, "R7 line zero");
        op_init(7, 0, 0, 0, 0);
        op_rd(2, "R7 code 7 full page");

        idle(4);
        check(wb_q.size() == 0 && rd_q.size() == 0, "R3 R6 all answered",
              32'(wb_q.size() + rd_q.size()), 32'd0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule